// File: doc/BRIEF.md
# SDRAM Initialization Command Issuer

This block lets software bring up a DDR or low-power DDR SDRAM one command at a time. Software first loads a 3-bit command code into a mode register. It then makes an ordinary write to the memory address space. That write carries no data. It triggers exactly one command of the chosen kind on the chip-select, row-strobe, column-strobe and write-enable pins. The write is acknowledged only after the command has appeared on the pins. The bank bits of the write address choose the target of a mode-register or extended-mode-register load. The row field of the address supplies the value that is loaded.

When the code is normal, writes become plain column WRITE commands. A refresh interval counter, programmed in controller clock cycles, then raises auto-refresh requests. A request stays pending until a refresh has actually been driven, and it takes precedence over a waiting write. After reset, the block keeps the bus quiet for a programmable settling time. The memory clock enable rises with the first NOP command.

Top module: `sdram_cmd_issuer`

## Requirements
- R1: While reset is asserted, clock enable is low, all four command pins are high (deselect), the acknowledge is low, and bank and address pins are zero.
- R2: Until PAUSE_CYC clock edges have passed since reset release, no command is driven and no write is acknowledged; a pending write is served once that time has passed.
- R3: With code 1, a write drives NOP (cs,ras,cas,we = 0,1,1,1). Clock enable rises in that same cycle and stays high until reset.
- R4: With code 2, a write drives precharge-all (0,0,1,0) with address pin 10 high, all other address pins low, and bank 0.
- R5: With codes 3 and 5, a write drives a mode-register load (0,0,0,0). The bank pins are byte-address bits 23:22 and the address pins are byte-address bits 21:10.
- R6: With code 4, each write drives one auto-refresh (0,0,0,1) with bank and address zero; two writes in a row give two refreshes.
- R7: With code 0, a write drives WRITE (0,1,0,0). The bank comes from byte-address bits 23:22 and the address pins carry column bits 9:1 zero-extended, so pin 10 is low.
- R8: A command is driven for exactly one cycle, in the cycle after the request is accepted, and the acknowledge is a one-cycle pulse in the cycle after the command. No new request is accepted before the cycle after the acknowledge.
- R9: Codes 6 and 7 acknowledge the write with the usual timing but drive no command.
- R10: With code 0 and a non-zero period P, a refresh request is raised every P cycles. Outside code 0, or with P zero, the interval counter is held at zero; writing the period restarts it.
- R11: A raised refresh request stays pending until an auto-refresh is driven for it. That happens only under code 0, and ahead of any write that is waiting at the same time.
- R12: A code write acts on requests accepted from the next cycle on; a request accepted in the same cycle as the code write uses the previous code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Load strobe for the command code |
| mode_wdata | input | 3 | Command code (0 normal, 1 NOP, 2 precharge-all, 3 mode load, 4 refresh, 5 extended mode load) |
| period_wr | input | 1 | Load strobe for the refresh interval |
| period_wdata | input | RC_W | Refresh interval in clock cycles, 0 stops the timer |
| mem_wr_req | input | 1 | Write request to memory space, held until acknowledged |
| mem_wr_addr | input | ADDR_W | Byte address of the write |
| mem_wr_ack | output | 1 | One-cycle acknowledge of the write |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address pins |
| sd_a | output | ROW_W | Address pins |

## Verification
Two functions can want the bus in the same cycle: expiry of the refresh interval and a write request under the normal code. The bench programs short intervals (5 and 8 cycles) and streams back-to-back normal writes, so expiries land on every phase of the write handshake. Some land while a write is already waiting, and some land while a command is on the bus. A behavioural model predicts every cycle which of the two wins and when the loser is served, and the pins and acknowledge are compared against it on every clock. A further case leaves the code away from normal while a request is pending, and checks that the request survives until normal mode returns.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  // command codes held in the mode register
  localparam logic [2:0] MC_NORMAL  = 3'd0;
  localparam logic [2:0] MC_NOP     = 3'd1;
  localparam logic [2:0] MC_PREALL  = 3'd2;
  localparam logic [2:0] MC_MODE    = 3'd3;
  localparam logic [2:0] MC_REFRESH = 3'd4;
  localparam logic [2:0] MC_EXTMODE = 3'd5;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    PINS_DESEL = 4'b1111,
    PINS_NOP   = 4'b0111,
    PINS_PRE   = 4'b0010,
    PINS_REF   = 4'b0001,
    PINS_LMR   = 4'b0000,
    PINS_WRITE = 4'b0100
  } cmd_pins_e;

  function automatic cmd_pins_e code_to_pins(input logic [2:0] code);
    case (code)
      MC_NORMAL:            return PINS_WRITE;
      MC_NOP:               return PINS_NOP;
      MC_PREALL:            return PINS_PRE;
      MC_MODE, MC_EXTMODE:  return PINS_LMR;
      MC_REFRESH:           return PINS_REF;
      default:              return PINS_DESEL;
    endcase
  endfunction

endpackage

// File: rtl/sci_pause_gate.sv
module sci_pause_gate #(
  parameter int PAUSE_CYC = 20000
) (
  input  logic clk,
  input  logic rst_n,
  output logic pause_done
);
  localparam int CW = (PAUSE_CYC < 2) ? 1 : $clog2(PAUSE_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      pause_done <= (PAUSE_CYC == 0);
    end else if (!pause_done) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(PAUSE_CYC - 1)) pause_done <= 1'b1;
    end
  end

  // R2
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pause_done |=> pause_done);

endmodule

// File: rtl/sci_refresh_timer.sv
module sci_refresh_timer #(
  parameter int RC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            period_wr,
  input  logic [RC_W-1:0] period_wdata,
  input  logic            run,
  input  logic            take,
  output logic            pend,
  output logic            expire
);
  logic [RC_W-1:0] period_q;
  logic [RC_W-1:0] cnt_q;
  logic            active;

  function automatic logic at_limit(input logic [RC_W-1:0] cnt,
                                    input logic [RC_W-1:0] per);
    return cnt == per - 1'b1;
  endfunction

  assign active = run && (period_q != '0);
  assign expire = active && at_limit(cnt_q, period_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      cnt_q    <= '0;
      pend     <= 1'b0;
    end else begin
      if (period_wr) period_q <= period_wdata;

      if (period_wr || !active || expire) cnt_q <= '0;
      else                                cnt_q <= cnt_q + 1'b1;

      if (expire)    pend <= 1'b1;
      else if (take) pend <= 1'b0;
    end
  end

  // R11
  pend_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend) |-> $past(take));

  // R10
  expire_only_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> run);

  // R10
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q < period_q));

endmodule

// File: rtl/sci_cmd_engine.sv
module sci_cmd_engine
  import sdram_cmd_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BYTE_OFS = 1,
  parameter int COL_W    = 9,
  parameter int ROW_W    = 12,
  parameter int BA_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic              pause_done,
  input  logic              ref_pend,
  input  logic              mem_wr_req,
  input  logic [ADDR_W-1:0] mem_wr_addr,
  output logic              ref_take,
  output logic              mem_wr_ack,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ROW_W-1:0]  sd_a
);
  localparam int ROW_LSB = BYTE_OFS + COL_W;
  localparam int BA_LSB  = ROW_LSB + ROW_W;
  localparam int AP_BIT  = 10;

  function automatic logic [BA_W-1:0] bank_of(input logic [ADDR_W-1:0] a);
    return a[BA_LSB +: BA_W];
  endfunction

  function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[ROW_LSB +: ROW_W];
  endfunction

  function automatic logic [ROW_W-1:0] col_of(input logic [ADDR_W-1:0] a);
    logic [ROW_W-1:0] r;
    r = '0;
    r[COL_W-1:0] = a[BYTE_OFS +: COL_W];
    return r;
  endfunction

  function automatic logic [ROW_W-1:0] preall_pins();
    logic [ROW_W-1:0] r;
    r = '0;
    r[AP_BIT] = 1'b1;
    return r;
  endfunction

  // named internal events
  logic      free;
  logic      take_ref;
  logic      take_wr;
  logic      cmd_vld_q;
  logic      wr_stage_q;
  cmd_pins_e cmd_q;
  cmd_pins_e cmd_d;
  logic [BA_W-1:0]  ba_d;
  logic [ROW_W-1:0] a_d;

  assign free     = pause_done && !cmd_vld_q && !mem_wr_ack;
  assign take_ref = free && (mode == MC_NORMAL) && ref_pend;
  assign take_wr  = free && !take_ref && mem_wr_req;
  assign ref_take = take_ref;

  always_comb begin
    cmd_d = PINS_DESEL;
    ba_d  = '0;
    a_d   = '0;
    if (take_ref) begin
      cmd_d = PINS_REF;
    end else if (take_wr) begin
      cmd_d = code_to_pins(mode);
      case (mode)
        MC_NORMAL: begin
          ba_d = bank_of(mem_wr_addr);
          a_d  = col_of(mem_wr_addr);
        end
        MC_PREALL: a_d = preall_pins();
        MC_MODE, MC_EXTMODE: begin
          ba_d = bank_of(mem_wr_addr);
          a_d  = row_of(mem_wr_addr);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= PINS_DESEL;
      sd_ba      <= '0;
      sd_a       <= '0;
      cmd_vld_q  <= 1'b0;
      wr_stage_q <= 1'b0;
      mem_wr_ack <= 1'b0;
      sd_cke     <= 1'b0;
    end else begin
      cmd_q      <= cmd_d;
      sd_ba      <= ba_d;
      sd_a       <= a_d;
      cmd_vld_q  <= take_ref || take_wr;
      wr_stage_q <= take_wr;
      mem_wr_ack <= wr_stage_q;
      if (take_wr && mode == MC_NOP) sd_cke <= 1'b1;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  // R8
  cmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cs_n |=> sd_cs_n);

  // R8
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_ack |=> !mem_wr_ack);

  // R8
  ack_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_ack |-> $past(take_wr, 2));

  // R2
  pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_done |-> (sd_cs_n && !mem_wr_ack));

  // R3
  cke_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cke |=> sd_cke);

  // R11
  ref_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free && mode == MC_NORMAL && ref_pend) |=> (cmd_q == PINS_REF && !wr_stage_q));

endmodule

// File: rtl/sdram_cmd_issuer.sv
module sdram_cmd_issuer
  import sdram_cmd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BYTE_OFS  = 1,
  parameter int COL_W     = 9,
  parameter int ROW_W     = 12,
  parameter int BA_W      = 2,
  parameter int RC_W      = 16,
  parameter int PAUSE_CYC = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [2:0]        mode_wdata,
  input  logic              period_wr,
  input  logic [RC_W-1:0]   period_wdata,
  input  logic              mem_wr_req,
  input  logic [ADDR_W-1:0] mem_wr_addr,
  output logic              mem_wr_ack,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ROW_W-1:0]  sd_a
);
  logic [2:0] mode_q;
  logic       pause_done;
  logic       ref_pend;
  logic       ref_expire;
  logic       ref_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MC_NORMAL;
    else if (mode_wr) mode_q <= mode_wdata;
  end

  // R12
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> $stable(mode_q));

  sci_pause_gate #(.PAUSE_CYC(PAUSE_CYC)) u_pause (
    .clk        (clk),
    .rst_n      (rst_n),
    .pause_done (pause_done)
  );

  sci_refresh_timer #(.RC_W(RC_W)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_wr    (period_wr),
    .period_wdata (period_wdata),
    .run          (mode_q == MC_NORMAL),
    .take         (ref_take),
    .pend         (ref_pend),
    .expire       (ref_expire)
  );

  sci_cmd_engine #(
    .ADDR_W   (ADDR_W),
    .BYTE_OFS (BYTE_OFS),
    .COL_W    (COL_W),
    .ROW_W    (ROW_W),
    .BA_W     (BA_W)
  ) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode_q),
    .pause_done  (pause_done),
    .ref_pend    (ref_pend),
    .mem_wr_req  (mem_wr_req),
    .mem_wr_addr (mem_wr_addr),
    .ref_take    (ref_take),
    .mem_wr_ack  (mem_wr_ack),
    .sd_cke      (sd_cke),
    .sd_cs_n     (sd_cs_n),
    .sd_ras_n    (sd_ras_n),
    .sd_cas_n    (sd_cas_n),
    .sd_we_n     (sd_we_n),
    .sd_ba       (sd_ba),
    .sd_a        (sd_a)
  );

  // R11
  take_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_take |-> (ref_pend && mode_q == MC_NORMAL));

  // R10
  expire_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_expire |=> ref_pend);

endmodule

// File: tb/sdram_cmd_issuer_test.sv
module sdram_cmd_issuer_test;
  localparam int PAUSE = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0;
  logic [2:0]  mode_wdata = '0;
  logic        period_wr = 1'b0;
  logic [15:0] period_wdata = '0;
  logic        mem_wr_req = 1'b0;
  logic [31:0] mem_wr_addr = '0;
  logic        mem_wr_ack;
  logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [11:0] sd_a;

  always #5 clk = ~clk;

  sdram_cmd_issuer #(.PAUSE_CYC(PAUSE)) uut (
    .clk(clk), .rst_n(rst_n),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .period_wr(period_wr), .period_wdata(period_wdata),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
    .mem_wr_ack(mem_wr_ack), .sd_cke(sd_cke),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_a(sd_a)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int    m_since, m_hold, m_mode, m_period, m_cnt, m_pend, m_wrstage;
  int    e_pins = 15, e_ba = 0, e_a = 0, e_ack = 0, e_cke = 0;
  string e_tag = "R1";
  int    exp_timer_refs = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_since = 0; m_hold = 0; m_mode = 0; m_period = 0; m_cnt = 0;
      m_pend = 0; m_wrstage = 0;
      e_pins = 15; e_ba = 0; e_a = 0; e_ack = 0; e_cke = 0; e_tag = "R1";
    end else begin
      bit free, tref, twr, expire;
      free   = (m_since >= PAUSE) && (m_hold == 0);
      tref   = free && m_mode == 0 && m_pend != 0;
      twr    = free && !tref && mem_wr_req;
      expire = m_mode == 0 && m_period != 0 && m_cnt == m_period - 1;

      e_ack = m_wrstage;
      m_wrstage = twr;
      e_pins = 15; e_ba = 0; e_a = 0;
      e_tag = (m_since < PAUSE) ? "R2" : (e_ack != 0 ? "R8" : "R8");
      if (tref) begin
        e_pins = 4'b0001; e_tag = "R11"; exp_timer_refs++;
      end else if (twr) begin
        case (m_mode)
          0: begin e_pins = 4'b0100; e_ba = mem_wr_addr[23:22]; e_a = mem_wr_addr[9:1]; e_tag = "R7"; end
          1: begin e_pins = 4'b0111; e_cke = 1; e_tag = "R3"; end
          2: begin e_pins = 4'b0010; e_a = 1 << 10; e_tag = "R4"; end
          3, 5: begin e_pins = 4'b0000; e_ba = mem_wr_addr[23:22]; e_a = mem_wr_addr[21:10]; e_tag = "R5"; end
          4: begin e_pins = 4'b0001; e_tag = "R6"; end
          default: e_tag = "R9";
        endcase
        if (mode_wr) e_tag = "R12";
      end

      if (tref)       m_hold = 1;
      else if (twr)   m_hold = 2;
      else if (m_hold > 0) m_hold--;

      if (expire)    m_pend = 1;
      else if (tref) m_pend = 0;

      if (period_wr) m_cnt = 0;
      else if (m_mode == 0 && m_period != 0) m_cnt = expire ? 0 : m_cnt + 1;
      else m_cnt = 0;

      if (period_wr) m_period = period_wdata;
      if (mode_wr)   m_mode = mode_wdata;
      if (m_since < 1000000) m_since++;
    end
  end

  // compare every clock, away from the active edge
  int obs_refs = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] pins;
      pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      chk(pins == 4'(e_pins), e_tag, "cmd pins", pins, e_pins);
      chk(sd_ba == 2'(e_ba), e_tag, "bank", sd_ba, e_ba);
      chk(sd_a == 12'(e_a), e_tag, "addr", sd_a, e_a);
      chk(mem_wr_ack == e_ack[0], "R8", "ack", mem_wr_ack, e_ack);
      chk(sd_cke == e_cke[0], "R3", "cke", sd_cke, e_cke);
      if (pins == 4'b0001 && uut.mode_q == 3'd0) obs_refs++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic set_mode(input int m);
    @(negedge clk); mode_wr = 1'b1; mode_wdata = 3'(m);
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic set_period(input int p);
    @(negedge clk); period_wr = 1'b1; period_wdata = 16'(p);
    @(negedge clk); period_wr = 1'b0;
  endtask

  task automatic mem_write(input logic [31:0] a);
    @(negedge clk); mem_wr_req = 1'b1; mem_wr_addr = a;
    do @(negedge clk); while (!mem_wr_ack);
    mem_wr_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    int lows;
    int r0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sd_cke == 1'b0 && mem_wr_ack == 1'b0, "R1", "cke/ack in reset", {sd_cke, mem_wr_ack}, 0);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'hF, "R1", "pins in reset",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 15);
    chk(sd_ba == 0 && sd_a == 0, "R1", "ba/a in reset", {sd_ba, sd_a}, 0);
    rst_n = 1'b1;

    // R2: request during the pause stays unserved
    set_mode(1);
    @(negedge clk); mem_wr_req = 1'b1; mem_wr_addr = 32'h2000_0000;
    lows = 0;
    repeat (PAUSE - 10) begin @(negedge clk); if (!sd_cs_n || mem_wr_ack) lows++; end
    chk(lows == 0, "R2", "activity during pause", lows, 0);
    do @(negedge clk); while (!mem_wr_ack);
    mem_wr_req = 1'b0;
    chk(sd_cke == 1'b1, "R3", "cke after NOP", sd_cke, 1);

    set_mode(2); mem_write(32'h2000_0000);
    set_mode(4); mem_write(32'h2000_1000); mem_write(32'h2000_2000);
    set_mode(3); mem_write(32'h2000_0000 | (32'h033 << 10));
    set_mode(5); mem_write(32'h2040_0000 | (32'h5A0 << 10));
    mem_write(32'h2080_0000 | (32'h002 << 10));

    // R9 reserved codes
    set_mode(6);
    lows = 0;
    fork
      mem_write(32'h2000_0040);
      repeat (4) begin @(negedge clk); if (!sd_cs_n) lows++; end
    join
    chk(lows == 0, "R9", "command on reserved code", lows, 0);
    set_mode(7); mem_write(32'h20C0_0080);

    // R12: code write coincides with request
    set_mode(0);
    @(negedge clk); mode_wr = 1'b1; mode_wdata = 3'd1; mem_wr_req = 1'b1; mem_wr_addr = 32'h20C0_03FE;
    @(negedge clk); mode_wr = 1'b0;
    while (!mem_wr_ack) @(negedge clk);
    mem_wr_req = 1'b0;
    set_mode(0);

    // R7 / R11 collisions: short interval with streaming writes
    set_period(5);
    for (int i = 0; i < 40; i++) mem_write(32'h2000_0000 + 32'(i * 32'h0004_1236));
    set_period(8);
    for (int i = 0; i < 30; i++) mem_write(32'h2040_0000 + 32'(i * 32'h0001_0402));

    // R10 steady-state rate with no writes
    repeat (20) @(negedge clk);
    r0 = obs_refs;
    repeat (80) @(negedge clk);
    chk(obs_refs - r0 == 10, "R10", "refreshes in 80 cycles at P=8", obs_refs - r0, 10);

    // R11: request kept while away from normal code
    set_mode(4);
    repeat (20) @(negedge clk);
    set_mode(0);
    repeat (5) @(negedge clk);
    set_period(0);
    repeat (20) @(negedge clk);
    chk(obs_refs == exp_timer_refs, "R11", "timer refresh count", obs_refs, exp_timer_refs);

    finish_run();
  end
endmodule